// File: doc/BRIEF.md
# Late-Write Buffer with Bypass

This block is the synchronous front end of a small on-chip memory that follows late-write timing. A command (read or write, single or double rate, with an address) is taken on a rising clock edge. For a write, the data follows on the next rising edge. Captured write data is not put into the storage array at once. It waits in a holding stage and is committed only when the data of the next write lands. A read that targets an address still parked in the holding stage is answered from that stage instead of the array.

A double-rate access moves two beats in one cycle over a port twice the word width. Beat 0 uses the command address. Beat 1 uses the same address with bit 0 inverted. Each beat is looked up against each parked beat on its own.

Read results leave output registers one cycle after the array lookup. The block also flags any write that is issued directly after a read, with no idle cycle between them.

Top module: `late_write_buffer`

## Requirements
- R1: While reset is applied and just after it, `rd_valid_o` and `protocol_error_o` are 0. The array and the holding stage are cleared and marked invalid, so every address reads back as zero until it is written.
- R2: A read command taken at rising edge T drives `rd_valid_o` high for exactly one cycle, starting right after edge T+1. No other cycle shows `rd_valid_o` high.
- R3: Write data for a command taken at edge T is sampled from `wr_data_i` at edge T+1. Beat 0 is on bits [DATA_W-1:0] and beat 1 is on bits [2*DATA_W-1:DATA_W].
- R4: For a double-rate access, beat 0 addresses `cmd_addr_i` and beat 1 addresses `cmd_addr_i` with bit 0 inverted. On reads, beat 0 comes back on the low half of `rd_data_o` and beat 1 on the high half.
- R5: A single-rate access uses beat 0 only. A single write changes only the command address. A single read returns zero on the high half of `rd_data_o`.
- R6: Every read returns the most recent data written to each of its addresses, counting all writes whose command was taken before the read command. This holds whether that data is still parked or already committed.
- R7: The parked-data lookup is done per beat. A read beat whose address equals either parked beat's address returns that parked beat, even when the beat numbers differ.
- R8: When a write command is taken at the edge right after a read command, `protocol_error_o` is high for exactly one cycle following that edge. The write is still carried out.
- R9: Writes have no byte enables. Each written beat replaces the whole stored word.
- R10: `rd_data_o` is zero in every cycle where `rd_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all state changes on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | A command is present this cycle |
| cmd_write_i | input | 1 | 1 = write, 0 = read |
| cmd_double_i | input | 1 | 1 = double rate (two beats), 0 = single rate |
| cmd_addr_i | input | ADDR_W | Word address of beat 0 |
| wr_data_i | input | 2*DATA_W | Write data, sampled the cycle after a write command |
| rd_valid_o | output | 1 | Read data is valid this cycle |
| rd_data_o | output | 2*DATA_W | Read data, beat 0 in the low half |
| protocol_error_o | output | 1 | One-cycle pulse: write issued directly after a read |

## Verification
Two functions can fall in the same cycle. The first case is a read whose command is taken on the same edge where the preceding write's data is parked and an older parked write is committed. The bench provokes it with write-then-read sequences on a narrow address range, so the lookup sees freshly parked beats while the array changes underneath. The second case is a read result leaving the output registers in the same cycle that a directly following write raises the protocol flag. Random read/write mixes produce this pairing often. In both cases the bench judges the result against a plain memory model that applies each write as soon as its data is driven, and it predicts the flag from the two previous commands.

// File: rtl/lwb_pkg.sv
package lwb_pkg;
   // number of beats carried by a double-rate access
   localparam int BEATS = 2;

   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } op_e;
endpackage

// File: rtl/lwb_cmd_stage.sv
module lwb_cmd_stage
   import lwb_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cmd_valid_i,
   input  logic              cmd_write_i,
   input  logic              cmd_double_i,
   input  logic [ADDR_W-1:0] cmd_addr_i,
   output op_e               s1_op_o,
   output logic              s1_double_o,
   output logic [ADDR_W-1:0] s1_addr_o,
   output logic              proto_err_o
);

   op_e next_op;

   always_comb begin
      if (!cmd_valid_i)     next_op = OP_IDLE;
      else if (cmd_write_i) next_op = OP_WRITE;
      else                  next_op = OP_READ;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         s1_op_o     <= OP_IDLE;
         s1_double_o <= 1'b0;
         s1_addr_o   <= '0;
         proto_err_o <= 1'b0;
      end else begin
         s1_op_o     <= next_op;
         proto_err_o <= (next_op == OP_WRITE) && (s1_op_o == OP_READ);
         if (cmd_valid_i) begin
            s1_double_o <= cmd_double_i;
            s1_addr_o   <= cmd_addr_i;
         end
      end
   end

   AST_ERR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      proto_err_o |=> !proto_err_o); // R8
   AST_ERR_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      proto_err_o |-> (s1_op_o == OP_WRITE)); // R8

endmodule

// File: rtl/lwb_hold.sv
module lwb_hold
   import lwb_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 16
) (
   input  logic                          clk_i,
   input  logic                          rst_ni,
   input  logic                          cap_en_i,
   input  logic                          cap_double_i,
   input  logic [ADDR_W-1:0]             cap_addr_i,
   input  logic [BEATS*DATA_W-1:0]       cap_data_i,
   input  logic [BEATS-1:0][ADDR_W-1:0]  look_addr_i,
   output logic [BEATS-1:0]              look_hit_o,
   output logic [BEATS-1:0][DATA_W-1:0]  look_data_o,
   output logic [BEATS-1:0]              commit_en_o,
   output logic [BEATS-1:0][ADDR_W-1:0]  commit_addr_o,
   output logic [BEATS-1:0][DATA_W-1:0]  commit_data_o
);

   logic [BEATS-1:0]             held_v;
   logic [BEATS-1:0][ADDR_W-1:0] held_a;
   logic [BEATS-1:0][DATA_W-1:0] held_d;

   // parked beats: replaced on every data capture, the old ones go to the array
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         held_v <= '0;
         held_a <= '0;
         held_d <= '0;
      end else if (cap_en_i) begin
         for (int b = 0; b < BEATS; b++) begin
            held_v[b] <= (b == 0) || cap_double_i;
            held_a[b] <= cap_addr_i ^ ADDR_W'(b);
            held_d[b] <= cap_data_i[b*DATA_W +: DATA_W];
         end
      end
   end

   for (genvar b = 0; b < BEATS; b++) begin : g_commit
      assign commit_en_o[b]   = cap_en_i && held_v[b];
      assign commit_addr_o[b] = held_a[b];
      assign commit_data_o[b] = held_d[b];
   end

   // per-beat lookup against every parked beat
   always_comb begin
      for (int r = 0; r < BEATS; r++) begin
         look_hit_o[r]  = 1'b0;
         look_data_o[r] = '0;
         for (int h = 0; h < BEATS; h++) begin
            if (held_v[h] && (held_a[h] == look_addr_i[r])) begin
               look_hit_o[r]  = 1'b1;
               look_data_o[r] = held_d[h];
            end
         end
      end
   end

   AST_HOLD_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(held_v[0]) |-> $past(cap_en_i)); // R3
   AST_HOLD_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      held_v[1] |-> held_v[0]); // R4

endmodule

// File: rtl/lwb_array.sv
module lwb_array
   import lwb_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 16
) (
   input  logic                          clk_i,
   input  logic                          rst_ni,
   input  logic [BEATS-1:0]              wr_en_i,
   input  logic [BEATS-1:0][ADDR_W-1:0]  wr_addr_i,
   input  logic [BEATS-1:0][DATA_W-1:0]  wr_data_i,
   input  logic [BEATS-1:0][ADDR_W-1:0]  rd_addr_i,
   output logic [BEATS-1:0][DATA_W-1:0]  rd_data_o
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
      end else begin
         for (int b = 0; b < BEATS; b++) begin
            if (wr_en_i[b]) mem[wr_addr_i[b]] <= wr_data_i[b];
         end
      end
   end

   for (genvar b = 0; b < BEATS; b++) begin : g_rd
      assign rd_data_o[b] = mem[rd_addr_i[b]];
   end

   AST_COMMIT_DISTINCT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (&wr_en_i) |-> (wr_addr_i[0] != wr_addr_i[1])); // R4

endmodule

// File: rtl/late_write_buffer.sv
module late_write_buffer
   import lwb_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 16
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic                      cmd_valid_i,
   input  logic                      cmd_write_i,
   input  logic                      cmd_double_i,
   input  logic [ADDR_W-1:0]         cmd_addr_i,
   input  logic [BEATS*DATA_W-1:0]   wr_data_i,
   output logic                      rd_valid_o,
   output logic [BEATS*DATA_W-1:0]   rd_data_o,
   output logic                      protocol_error_o
);

   localparam int BUS_W = BEATS * DATA_W;

   if (ADDR_W < 2) begin : g_bad_addr
      $error("late_write_buffer: ADDR_W must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("late_write_buffer: DATA_W must be at least 1");
   end

   op_e                          s1_op;
   logic                         s1_double;
   logic [ADDR_W-1:0]            s1_addr;
   logic [BEATS-1:0][ADDR_W-1:0] beat_addr;
   logic [BEATS-1:0]             hit;
   logic [BEATS-1:0][DATA_W-1:0] hit_data;
   logic [BEATS-1:0][DATA_W-1:0] arr_data;
   logic [BEATS-1:0]             cm_en;
   logic [BEATS-1:0][ADDR_W-1:0] cm_addr;
   logic [BEATS-1:0][DATA_W-1:0] cm_data;
   logic [BUS_W-1:0]             rd_next;
   logic                         s1_read;

   lwb_cmd_stage #(.ADDR_W(ADDR_W)) u_cmd (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .cmd_valid_i  (cmd_valid_i),
      .cmd_write_i  (cmd_write_i),
      .cmd_double_i (cmd_double_i),
      .cmd_addr_i   (cmd_addr_i),
      .s1_op_o      (s1_op),
      .s1_double_o  (s1_double),
      .s1_addr_o    (s1_addr),
      .proto_err_o  (protocol_error_o)
   );

   for (genvar b = 0; b < BEATS; b++) begin : g_beat_addr
      assign beat_addr[b] = s1_addr ^ ADDR_W'(b);
   end

   lwb_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .cap_en_i      (s1_op == OP_WRITE),
      .cap_double_i  (s1_double),
      .cap_addr_i    (s1_addr),
      .cap_data_i    (wr_data_i),
      .look_addr_i   (beat_addr),
      .look_hit_o    (hit),
      .look_data_o   (hit_data),
      .commit_en_o   (cm_en),
      .commit_addr_o (cm_addr),
      .commit_data_o (cm_data)
   );

   lwb_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (cm_en),
      .wr_addr_i (cm_addr),
      .wr_data_i (cm_data),
      .rd_addr_i (beat_addr),
      .rd_data_o (arr_data)
   );

   assign s1_read = (s1_op == OP_READ);

   always_comb begin
      rd_next = '0;
      for (int b = 0; b < BEATS; b++) begin
         if (s1_read && ((b == 0) || s1_double)) begin
            rd_next[b*DATA_W +: DATA_W] = hit[b] ? hit_data[b] : arr_data[b];
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rd_valid_o <= 1'b0;
         rd_data_o  <= '0;
      end else begin
         rd_valid_o <= s1_read;
         rd_data_o  <= rd_next;
      end
   end

   AST_READ_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_valid_i && !cmd_write_i) |=> ##1 rd_valid_o); // R2
   AST_NO_SPURIOUS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(cmd_valid_i && !cmd_write_i) |=> ##1 !rd_valid_o); // R2
   AST_SINGLE_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_valid_i && !cmd_write_i && !cmd_double_i) |=> ##1
      (rd_data_o[BUS_W-1:DATA_W] == '0)); // R5
   AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_valid_o |-> (rd_data_o == '0)); // R10

endmodule

// File: tb/tb_late_write_buffer.sv
`timescale 1ns/1ps
module tb_late_write_buffer;
   localparam int AW = 6;
   localparam int DW = 16;
   localparam int BW = 2 * DW;
   localparam int OPI = 0;
   localparam int OPR = 1;
   localparam int OPW = 2;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          cmd_valid, cmd_write, cmd_double;
   logic [AW-1:0] cmd_addr;
   logic [BW-1:0] wr_data;
   logic          rd_valid;
   logic [BW-1:0] rd_data;
   logic          perr;

   always #2 clk = ~clk;

   late_write_buffer #(.ADDR_W(AW), .DATA_W(DW)) dut (
      .clk_i            (clk),
      .rst_ni           (rst_n),
      .cmd_valid_i      (cmd_valid),
      .cmd_write_i      (cmd_write),
      .cmd_double_i     (cmd_double),
      .cmd_addr_i       (cmd_addr),
      .wr_data_i        (wr_data),
      .rd_valid_o       (rd_valid),
      .rd_data_o        (rd_data),
      .protocol_error_o (perr)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   logic [DW-1:0] model [1 << AW];

   // expectation pipeline
   bit            p1_v, p2_v;
   logic [BW-1:0] p1_d, p2_d;
   string         p1_tag, p2_tag;
   int            prev1_op, prev2_op;
   bit            pend_w, pend_dbl;
   logic [AW-1:0] pend_a;
   logic [BW-1:0] pend_d;

   task automatic chk(input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [BW-1:0] expect_read(input logic [AW-1:0] a, input bit dbl);
      logic [BW-1:0] v;
      v = '0;
      v[DW-1:0] = model[a];
      if (dbl) v[BW-1:DW] = model[a ^ AW'(1)];
      return v;
   endfunction

   task automatic step(input int op, input bit dbl, input logic [AW-1:0] a,
                       input logic [BW-1:0] d, input string tag);
      @(negedge clk);
      chk("R2", BW'(rd_valid), BW'(p2_v));
      if (p2_v) chk(p2_tag, rd_data, p2_d);
      else      chk("R10", rd_data, '0);
      chk("R8", BW'(perr), BW'((prev1_op == OPW) && (prev2_op == OPR)));
      // data of the previous write goes out now (R3)
      wr_data = pend_w ? pend_d : BW'($urandom);
      if (pend_w) begin
         model[pend_a] = pend_d[DW-1:0];
         if (pend_dbl) model[pend_a ^ AW'(1)] = pend_d[BW-1:DW];
      end
      cmd_valid  = (op != OPI);
      cmd_write  = (op == OPW);
      cmd_double = dbl;
      cmd_addr   = a;
      p2_v = p1_v; p2_d = p1_d; p2_tag = p1_tag;
      p1_v = (op == OPR);
      p1_d = (op == OPR) ? expect_read(a, dbl) : '0;
      p1_tag = tag;
      prev2_op = prev1_op;
      prev1_op = op;
      pend_w = (op == OPW); pend_dbl = dbl; pend_a = a; pend_d = d;
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired, all requirements");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < (1 << AW); i++) model[i] = '0;
      p1_v = 0; p2_v = 0; p1_d = '0; p2_d = '0; p1_tag = "R6"; p2_tag = "R6";
      prev1_op = OPI; prev2_op = OPI;
      pend_w = 0; pend_dbl = 0; pend_a = '0; pend_d = '0;
      rst_n = 1'b0; cmd_valid = 0; cmd_write = 0; cmd_double = 0;
      cmd_addr = '0; wr_data = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      chk("R1", BW'(rd_valid), '0);
      chk("R1", BW'(perr), '0);
      chk("R1", rd_data, '0);
      rst_n = 1'b1;

      step(OPR, 1, 6'd5, '0, "R1");              // R1: cleared array reads zero
      step(OPI, 0, 6'd0, '0, "R10");
      step(OPW, 0, 6'd3, 32'h0000_1234, "R3");   // R3: data one cycle later
      step(OPR, 0, 6'd3, '0, "R6");              // R6: parked data via bypass
      step(OPI, 0, 6'd0, '0, "R10");
      step(OPW, 1, 6'd8, 32'hBEEF_CAFE, "R4");   // R4: beats at 8 and 9
      step(OPI, 0, 6'd0, '0, "R10");
      step(OPR, 0, 6'd9, '0, "R7");              // R7: single read hits parked beat 1
      step(OPR, 1, 6'd9, '0, "R7");              // R7: beat order swapped vs held
      step(OPI, 0, 6'd0, '0, "R10");
      step(OPW, 0, 6'd20, 32'hAAAA_FFFF, "R9");
      step(OPW, 0, 6'd20, 32'h5555_0001, "R9");  // R9: full word replaced
      step(OPW, 1, 6'd40, 32'h0102_0304, "R6");  // commits the second write
      step(OPR, 0, 6'd20, '0, "R9");
      step(OPR, 1, 6'd40, '0, "R4");
      step(OPR, 0, 6'd41, '0, "R5");             // R5: upper half zero
      step(OPW, 0, 6'd41, 32'h0000_7777, "R8");  // R8: write right after read
      step(OPI, 0, 6'd0, '0, "R10");
      step(OPR, 1, 6'd40, '0, "R5");             // R5: single write touched 41 only
      step(OPI, 0, 6'd0, '0, "R10");
      step(OPI, 0, 6'd0, '0, "R10");

      for (int n = 0; n < 4000; n++) begin
         int            op;
         bit            dbl;
         logic [AW-1:0] a;
         op  = int'($urandom_range(0, 2));
         dbl = 1'($urandom_range(0, 1));
         a   = AW'($urandom_range(0, 11));
         step(op, dbl, a, BW'($urandom), dbl ? "R4" : "R6");
      end
      repeat (4) step(OPI, 0, 6'd0, '0, "R10");

      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule